// File: doc/BRIEF.md
# Multichannel Sample Word Packer

The packer sits between a converter interface and a DMA write stream, in the sample clock domain. It receives four 16-bit sample lanes, the I and Q of channel 0 and the I and Q of channel 1. Each lane has its own enable and its own valid. Each sample holds 12 significant bits inside its 16-bit lane, and the packer passes all 16 bits through unchanged. Only the enabled lanes are gathered into 64-bit output words, so downstream buffers are always whole multiples of 64 bits.

The enable pattern selects the packing ratio at run time:

- **One lane enabled:** four successive samples make one word.
- **One channel's I and Q enabled:** two successive 32-bit IQ pairs make one word.
- **All lanes enabled:** each sample time yields a whole word.

Every word is presented for one cycle with a valid pulse. A sync flag marks the first word built after reset or after a change of the enable set. That word is the first that starts on a clean boundary.

Top module: `adc_lane_packer`

## Requirements
- R1: While rst_ni is low, and on the first edge after it rises, word_vld_o and word_sync_o are 0 and word_o is all zeros.
- R2: All-lanes mode (lane_en_i = 4'b1111) produces one word per accepted sample time. The word layout is I0 in bits 15:0, Q0 in bits 31:16, I1 in bits 47:32 and Q1 in bits 63:48. The word is presented on the clock edge after the one that accepted the sample.
- R3: Single-lane mode (exactly one lane_en_i bit set) packs four accepted samples of that lane into one word. The earliest sample is in bits 15:0 and the latest in bits 63:48. The word appears after the edge that accepts the fourth sample.
- R4: Pair mode is selected by lane_en_i = 4'b0011 (I0 and Q0) or 4'b1100 (I1 and Q1). Each accepted sample time contributes the 32-bit pair {Q,I}, with I in the lower half. Two pairs make a word, and the earlier pair sits in bits 31:0.
- R5: A sample time is accepted only when the lane_vld_i bit of every lane counted by the current mode is 1. The valid bits of lanes outside the mode, and the data of those lanes, have no effect on the output.
- R6: Any enable pattern other than those of R3 and R4, including 4'b0000, is packed exactly as in all-lanes mode.
- R7: When lane_en_i differs from its value in the previous cycle, any partly built word is discarded without output. A sample accepted in that same cycle goes into slot 0 under the new mode.
- R8: word_vld_o is 1 for exactly one cycle per completed word and 0 otherwise. word_o keeps the last completed word until the next one completes.
- R9: word_sync_o is 1, together with word_vld_o, on the first word completed after reset or after an enable change, and is 0 on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_data_i | input | 64 | Lane samples; lane k at bits 16k+15:16k, ordered I0, Q0, I1, Q1 |
| lane_en_i | input | 4 | Per-lane enable, bit k for lane k |
| lane_vld_i | input | 4 | Per-lane valid, bit k for lane k |
| word_o | output | 64 | Last completed packed word |
| word_vld_o | output | 1 | One-cycle pulse per completed word |
| word_sync_o | output | 1 | Marks the first word after reset or an enable change |

## Verification
An enable change and a word completion can fall on the same edge. This happens in all-lanes mode, where a single accepted sample both restarts packing and completes a word. The bench provokes it by switching from one enable pattern to an unlisted pattern, and again to all-zero enables, while every valid is high. The bench then expects the new word to appear at once with word_sync_o raised, rather than being swallowed by the flush. A second case checks that a flush landing on a partly filled single-lane or pair word yields no output, and that the word completed next is built only from samples taken after the change.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned SLOT_W = 2;

  typedef enum logic [1:0] {
    PK_ALL  = 2'd0,
    PK_PAIR = 2'd1,
    PK_ONE  = 2'd2
  } pack_mode_e;

  function automatic logic [SLOT_W-1:0] last_slot(input pack_mode_e m);
    case (m)
      PK_ONE:  return SLOT_W'(3);
      PK_PAIR: return SLOT_W'(1);
      default: return SLOT_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/lane_mode_decode.sv
module lane_mode_decode
  import adc_pack_pkg::*;
#(
  parameter int unsigned N_LANES = LANES,
  localparam int unsigned IDX_W  = $clog2(N_LANES)
) (
  input  logic [N_LANES-1:0] en_i,
  output pack_mode_e         mode_o,
  output logic [IDX_W-1:0]   base_o,
  output logic [N_LANES-1:0] need_o
);
  localparam logic [N_LANES-1:0] PAIR0 = N_LANES'(4'b0011);
  localparam logic [N_LANES-1:0] PAIR1 = N_LANES'(4'b1100);

  logic one_hot;
  logic [IDX_W-1:0] hot_idx;

  always_comb begin
    hot_idx = '0;
    for (int k = 0; k < int'(N_LANES); k++) begin
      if (en_i[k]) hot_idx = IDX_W'(k);
    end
  end

  assign one_hot = (en_i != '0) && ((en_i & (en_i - 1'b1)) == '0);

  always_comb begin
    mode_o = PK_ALL;
    base_o = '0;
    need_o = '1;
    if (one_hot) begin
      mode_o = PK_ONE;
      base_o = hot_idx;
      need_o = en_i;
    end else if (en_i == PAIR0) begin
      mode_o = PK_PAIR;
      base_o = IDX_W'(0);
      need_o = PAIR0;
    end else if (en_i == PAIR1) begin
      mode_o = PK_PAIR;
      base_o = IDX_W'(2);
      need_o = PAIR1;
    end
  end
endmodule

// File: rtl/lane_slot_place.sv
module lane_slot_place
  import adc_pack_pkg::*;
#(
  parameter int unsigned LANE_W  = 16,
  parameter int unsigned N_LANES = LANES,
  localparam int unsigned WORD_W = LANE_W * N_LANES,
  localparam int unsigned IDX_W  = $clog2(N_LANES)
) (
  input  pack_mode_e        mode_i,
  input  logic [IDX_W-1:0]  base_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [WORD_W-1:0] lanes_i,
  output logic [WORD_W-1:0] chunk_o,
  output logic [WORD_W-1:0] mask_o
);
  logic [LANE_W-1:0]   one_piece;
  logic [2*LANE_W-1:0] pair_piece;
  logic [WORD_W-1:0]   one_ext, pair_ext, one_ones, pair_ones;

  assign one_piece  = lanes_i[int'(base_i)*LANE_W +: LANE_W];
  assign pair_piece = lanes_i[int'(base_i)*LANE_W +: 2*LANE_W];
  assign one_ext    = WORD_W'(one_piece);
  assign pair_ext   = WORD_W'(pair_piece);
  assign one_ones   = WORD_W'({LANE_W{1'b1}});
  assign pair_ones  = WORD_W'({2*LANE_W{1'b1}});

  always_comb begin
    case (mode_i)
      PK_ONE: begin
        chunk_o = one_ext << (int'(slot_i) * LANE_W);
        mask_o  = one_ones << (int'(slot_i) * LANE_W);
      end
      PK_PAIR: begin
        chunk_o = pair_ext << (int'(slot_i) * 2 * LANE_W);
        mask_o  = pair_ones << (int'(slot_i) * 2 * LANE_W);
      end
      default: begin
        chunk_o = lanes_i;
        mask_o  = '1;
      end
    endcase
  end
endmodule

// File: rtl/word_assembler.sv
module word_assembler
  import adc_pack_pkg::*;
#(
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              restart_i,
  input  logic [SLOT_W-1:0] last_i,
  input  logic [WORD_W-1:0] chunk_i,
  input  logic [WORD_W-1:0] mask_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [WORD_W-1:0] word_o,
  output logic              vld_o,
  output logic              sync_o
);
  logic [SLOT_W-1:0] slot_q;
  logic [WORD_W-1:0] acc_q, acc_base, acc_next;
  logic              pend_q, done;

  // restart drops the partial word and rewinds to slot 0
  assign slot_o   = restart_i ? '0 : slot_q;
  assign acc_base = restart_i ? '0 : acc_q;
  assign acc_next = (acc_base & ~mask_i) | chunk_i;
  assign done     = take_i && (slot_o == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      acc_q  <= '0;
      word_o <= '0;
      vld_o  <= 1'b0;
      sync_o <= 1'b0;
      pend_q <= 1'b1;
    end else begin
      vld_o  <= done;
      sync_o <= done && (pend_q || restart_i);
      if (done) begin
        word_o <= acc_next;
        acc_q  <= '0;
        slot_q <= '0;
        pend_q <= 1'b0;
      end else begin
        if (take_i) begin
          acc_q  <= acc_next;
          slot_q <= slot_o + 1'b1;
        end else if (restart_i) begin
          acc_q  <= '0;
          slot_q <= '0;
        end
        if (restart_i) pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_lane_packer.sv
module adc_lane_packer
  import adc_pack_pkg::*;
#(
  parameter int unsigned LANE_W  = 16,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned IDX_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] lane_data_i,
  input  logic [LANES-1:0]  lane_en_i,
  input  logic [LANES-1:0]  lane_vld_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              word_sync_o
);
  pack_mode_e        mode;
  logic [IDX_W-1:0]  base;
  logic [LANES-1:0]  need, en_q;
  logic [SLOT_W-1:0] slot;
  logic [WORD_W-1:0] chunk, mask;
  logic              take, restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '1;
    else         en_q <= lane_en_i;
  end

  assign restart = (lane_en_i != en_q);
  assign take    = &(lane_vld_i | ~need);

  lane_mode_decode #(.N_LANES(LANES)) u_dec (
    .en_i   (lane_en_i),
    .mode_o (mode),
    .base_o (base),
    .need_o (need)
  );

  lane_slot_place #(.LANE_W(LANE_W), .N_LANES(LANES)) u_place (
    .mode_i  (mode),
    .base_i  (base),
    .slot_i  (slot),
    .lanes_i (lane_data_i),
    .chunk_o (chunk),
    .mask_o  (mask)
  );

  word_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .restart_i (restart),
    .last_i    (last_slot(mode)),
    .chunk_i   (chunk),
    .mask_i    (mask),
    .slot_o    (slot),
    .word_o    (word_o),
    .vld_o     (word_vld_o),
    .sync_o    (word_sync_o)
  );
endmodule

// File: rtl/adc_lane_packer_chk.sv
module adc_lane_packer_chk #(
  parameter int unsigned LANE_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [4*LANE_W-1:0] lane_data_i,
  input logic [3:0]          lane_en_i,
  input logic [3:0]          lane_vld_i,
  input logic [4*LANE_W-1:0] word_o,
  input logic                word_vld_o,
  input logic                word_sync_o
);
  logic [1:0] age;
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= '0;
    else if (age != 2'd2) age <= age + 1'b1;
  end
  assign armed = (age == 2'd2);

  // R9
  sync_needs_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_sync_o |-> word_vld_o);

  // R2
  all_lane_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(lane_en_i == 4'hF && lane_vld_i == 4'hF)
      |-> word_vld_o && word_o == $past(lane_data_i));

  // R5
  all_lane_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(lane_en_i == 4'hF && lane_vld_i != 4'hF) |-> !word_vld_o);

  // R7
  single_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past($countones(lane_en_i) == 1) && $past(lane_en_i) != $past(lane_en_i, 2)
      |-> !word_vld_o);

  // R8
  hold_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !word_vld_o |-> $stable(word_o));

  // R1
  known_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({word_vld_o, word_sync_o}));
endmodule

bind adc_lane_packer adc_lane_packer_chk #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/sim_adc_lane_packer.sv
`timescale 1ns/1ps
module sim_adc_lane_packer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] lane_data_i = '0;
  logic [3:0]  lane_en_i = 4'hF;
  logic [3:0]  lane_vld_i = 4'h0;
  logic [63:0] word_o;
  logic        word_vld_o, word_sync_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  adc_lane_packer u0 (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  en;
    logic [3:0]  vld;
    logic [63:0] din;
    logic        ev;
    logic        es;
    logic [63:0] ew;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    // R2 R9 all lanes, first word after reset
    '{4'd2, 4'hF, 4'hF, 64'h4444_3333_2222_1111, 1'b1, 1'b1, 64'h4444_3333_2222_1111},
    '{4'd2, 4'hF, 4'hF, 64'h8888_7777_6666_5555, 1'b1, 1'b0, 64'h8888_7777_6666_5555},
    // R5 one lane invalid
    '{4'd5, 4'hF, 4'h7, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, 1'b0, 64'h8888_7777_6666_5555},
    // R3 single lane I0, foreign valids/data ignored (R5)
    '{4'd3, 4'h1, 4'h1, 64'h0000_0000_0000_0A01, 1'b0, 1'b0, 64'h8888_7777_6666_5555},
    '{4'd5, 4'h1, 4'hF, 64'hFFFF_FFFF_FFFF_0A02, 1'b0, 1'b0, 64'h8888_7777_6666_5555},
    '{4'd5, 4'h1, 4'hE, 64'h0000_0000_0000_0A99, 1'b0, 1'b0, 64'h8888_7777_6666_5555},
    '{4'd3, 4'h1, 4'h1, 64'h0000_0000_0000_0A03, 1'b0, 1'b0, 64'h8888_7777_6666_5555},
    '{4'd3, 4'h1, 4'h1, 64'h1234_0000_0000_0A04, 1'b1, 1'b1, 64'h0A04_0A03_0A02_0A01},
    // R7 single lane I1, then switched away mid-word
    '{4'd7, 4'h4, 4'h4, 64'h0000_0B01_0000_0000, 1'b0, 1'b0, 64'h0A04_0A03_0A02_0A01},
    '{4'd7, 4'h4, 4'h4, 64'h0000_0B02_0000_0000, 1'b0, 1'b0, 64'h0A04_0A03_0A02_0A01},
    // R4 pair ch0 after flush
    '{4'd4, 4'h3, 4'h3, 64'h0000_0000_0C02_0C01, 1'b0, 1'b0, 64'h0A04_0A03_0A02_0A01},
    '{4'd4, 4'h3, 4'h3, 64'h0000_0000_0C04_0C03, 1'b1, 1'b1, 64'h0C04_0C03_0C02_0C01},
    '{4'd5, 4'h3, 4'hD, 64'h0000_0000_0CEE_0CEE, 1'b0, 1'b0, 64'h0C04_0C03_0C02_0C01},
    '{4'd4, 4'h3, 4'h3, 64'h0000_0000_0C06_0C05, 1'b0, 1'b0, 64'h0C04_0C03_0C02_0C01},
    '{4'd8, 4'h3, 4'h3, 64'h0000_0000_0C08_0C07, 1'b1, 1'b0, 64'h0C08_0C07_0C06_0C05},
    // R4 pair ch1
    '{4'd4, 4'hC, 4'hC, 64'h0D02_0D01_0000_0000, 1'b0, 1'b0, 64'h0C08_0C07_0C06_0C05},
    '{4'd4, 4'hC, 4'hC, 64'h0D04_0D03_0000_0000, 1'b1, 1'b1, 64'h0D04_0D03_0D02_0D01},
    // R6 unlisted pattern acts as all lanes; change and completion together (R9)
    '{4'd6, 4'h5, 4'hF, 64'h5004_5003_5002_5001, 1'b1, 1'b1, 64'h5004_5003_5002_5001},
    '{4'd6, 4'h5, 4'hF, 64'h6004_6003_6002_6001, 1'b1, 1'b0, 64'h6004_6003_6002_6001},
    '{4'd9, 4'h0, 4'hF, 64'h7004_7003_7002_7001, 1'b1, 1'b1, 64'h7004_7003_7002_7001},
    // partial single-lane word left for the reset test
    '{4'd8, 4'h1, 4'h1, 64'h0000_0000_0000_0E01, 1'b0, 1'b0, 64'h7004_7003_7002_7001},
    '{4'd8, 4'h1, 4'h1, 64'h0000_0000_0000_0E02, 1'b0, 1'b0, 64'h7004_7003_7002_7001},
    '{4'd8, 4'h1, 4'h0, 64'h0000_0000_0000_0E03, 1'b0, 1'b0, 64'h7004_7003_7002_7001}
  };

  task automatic check(input int req, input logic ev, input logic es, input logic [63:0] ew);
    n_chk++;
    if (word_vld_o !== ev || word_sync_o !== es || word_o !== ew) begin
      n_bad++;
      $display("FAIL R%0d: got vld=%b sync=%b word=%h, expected vld=%b sync=%b word=%h",
               req, word_vld_o, word_sync_o, word_o, ev, es, ew);
    end
  endtask

  task automatic step(input logic [3:0] en, input logic [3:0] vld, input logic [63:0] din);
    lane_en_i   = en;
    lane_vld_i  = vld;
    lane_data_i = din;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(1, 1'b0, 1'b0, 64'h0); // R1 in reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, 1'b0, 1'b0, 64'h0); // R1 first edge after release
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].en, VEC[i].vld, VEC[i].din);
      check(int'(VEC[i].req), VEC[i].ev, VEC[i].es, VEC[i].ew);
    end
    // R1 reset in the middle of a partial word
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(1, 1'b0, 1'b0, 64'h0);
    rst_ni = 1'b1;
    // R3 R9 fresh word built only from post-reset samples
    step(4'h1, 4'h1, 64'h0000_0000_0000_00F1);
    check(3, 1'b0, 1'b0, 64'h0);
    step(4'h1, 4'h1, 64'h0000_0000_0000_00F2);
    step(4'h1, 4'h1, 64'h0000_0000_0000_00F3);
    step(4'h1, 4'h1, 64'h0000_0000_0000_00F4);
    check(9, 1'b1, 1'b1, 64'h00F4_00F3_00F2_00F1);
    // R8 pulse ends, word held
    step(4'h1, 4'h0, 64'h0);
    check(8, 1'b0, 1'b0, 64'h00F4_00F3_00F2_00F1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8: watchdog expired, got no completion, expected end of run");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule